// File: doc/BRIEF.md
# Adaptive Back-EMF Zero-Crossing Mask Timer

A sensorless spindle drive finds rotor position by watching the back-EMF comparator for a change of level. Each commutation step disturbs the floating phase. The comparator can then toggle falsely for a short time. This block blanks that window, and the window grows and shrinks with motor speed.

Every valid change of comparator level is a zero crossing. The block times the gap between successive zero crossings with a slow up counter, which saturates instead of wrapping. At each zero crossing it keeps the upper bits of that count. When the sequencer advances, that stored value seeds a down counter, which runs at half the rate of the up counter. The mask therefore lasts about one quarter of the last zero-crossing period. While the mask is open, comparator changes are discarded. They do not restart the period measurement, and the masked comparator output keeps its last accepted level.

All logic runs on the reference clock. The comparator level is synchronised before edge detection. The commutation strobe is a single-cycle pulse in the same clock domain.

Top module: `bemf_mask_timer`

## Requirements
- R1: While reset is asserted, `mask_active`, `zc_strobe` and `cmp_masked` are 0. The period counter, the stored load value and the mask counter are cleared, and no zero crossing has yet been seen.
- R2: `cmp_raw` passes through a two-stage synchroniser. A level change driven during cycle k gives a one-cycle `zc_strobe` in cycle k+2, provided the mask is inactive in that cycle.
- R3: A free-running prescaler starts from zero at reset release. The period counter advances at the end of every cycle n with n mod 64 = 63 (n counts clock edges since reset release). It stops at 511 instead of wrapping.
- R4: On each zero crossing the period counter restarts from 0. If an earlier zero crossing has been seen since reset, the top 6 bits of the 9-bit count (count >> 3) are stored as the mask load value. The first zero crossing after reset only starts measurement and leaves the load value at 0.
- R5: A commutation pulse in cycle c copies the stored load value into the mask counter. `mask_active` is high from cycle c+1 for as long as that counter is nonzero. A load value of 0 produces no mask.
- R6: The mask counter decrements at the end of every cycle n with n mod 128 = 127, so it runs at half the period-counter rate. The mask therefore lasts about a quarter of the measured period, with the fraction truncated.
- R7: Comparator level changes whose edge falls in a masked cycle give no `zc_strobe`. They neither restart nor store the period count.
- R8: `cmp_masked` takes the synchronised comparator level in each cycle the mask is inactive, so a change in cycle k shows in cycle k+3. It holds its value throughout the mask.
- R9: A period of more than 511 prescaled ticks saturates and stores the load value 63, which gives the longest mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commutate | input | 1 | One-cycle pulse when the sequencer advances |
| cmp_raw | input | 1 | Asynchronous back-EMF comparator level |
| mask_active | output | 1 | High while comparator changes are blanked |
| zc_strobe | output | 1 | One-cycle pulse on a qualified zero crossing |
| cmp_masked | output | 1 | Comparator level, frozen while masked |

## Verification
The bench builds the block with its default parameters: a 9-bit period counter, a 6-bit mask counter, a divide-by-64 prescaler and two synchroniser stages. With these values the bench can reach a saturated period of more than 32,704 cycles inside its run, which yields the full 63-step mask. It also covers short periods that truncate to a load of 1 and to a load of 0. A crossing placement is chosen so that wrongly accepting the masked toggles would move the stored load from 5 to 4. The bench predicts every strobe cycle, every mask edge and every change of the frozen output from the fixed prescaler phase since reset.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int unsigned BMT_PER_W_DEF  = 9;
  localparam int unsigned BMT_MASK_W_DEF = 6;
  localparam int unsigned BMT_UP_DIV_DEF = 64;
  localparam int unsigned BMT_SYNC_DEF   = 2;

  // Quarter-period load: keep the upper bits of the period count.
  function automatic int unsigned bmt_quarter_load(input int unsigned period,
                                                   input int unsigned shift);
    return period >> shift;
  endfunction

  // Saturating increment up to lim.
  function automatic int unsigned bmt_sat_inc(input int unsigned v,
                                              input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/bmt_prescaler.sv
module bmt_prescaler #(
  parameter int unsigned UP_DIV = bmt_pkg::BMT_UP_DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic up_tick,
  output logic dn_tick
);
  localparam int unsigned UP_LOG = $clog2(UP_DIV);
  localparam int unsigned DIV_W  = UP_LOG + 1;

  logic [DIV_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  // Up tick every UP_DIV cycles, down tick every 2*UP_DIV cycles.
  assign up_tick = &div_cnt[UP_LOG-1:0];
  assign dn_tick = &div_cnt;
endmodule

// File: rtl/bmt_cmp_front.sv
module bmt_cmp_front #(
  parameter int unsigned SYNC_STAGES = bmt_pkg::BMT_SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw,
  input  logic freeze,
  output logic cmp_edge,
  output logic cmp_held
);
  logic [SYNC_STAGES-1:0] stage;
  logic cmp_sync;
  logic cmp_prev;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= 1'b0;
        else        stage[0] <= cmp_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage[i] <= 1'b0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign cmp_sync = stage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_prev <= 1'b0;
      cmp_held <= 1'b0;
    end else begin
      cmp_prev <= cmp_sync;
      if (!freeze) cmp_held <= cmp_sync;
    end
  end

  assign cmp_edge = cmp_sync ^ cmp_prev;
endmodule

// File: rtl/bmt_period.sv
module bmt_period #(
  parameter int unsigned PER_W  = bmt_pkg::BMT_PER_W_DEF,
  parameter int unsigned MASK_W = bmt_pkg::BMT_MASK_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_tick,
  input  logic              zc,
  output logic [PER_W-1:0]  per_cnt,
  output logic [MASK_W-1:0] hold_load,
  output logic              armed
);
  localparam int unsigned SHIFT   = PER_W - MASK_W;
  localparam int unsigned PER_MAX = (1 << PER_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt   <= '0;
      hold_load <= '0;
      armed     <= 1'b0;
    end else if (zc) begin
      per_cnt <= '0;
      armed   <= 1'b1;
      if (armed)
        hold_load <= MASK_W'(bmt_pkg::bmt_quarter_load(32'(per_cnt), SHIFT));
    end else if (armed && up_tick) begin
      per_cnt <= PER_W'(bmt_pkg::bmt_sat_inc(32'(per_cnt), PER_MAX));
    end
  end
endmodule

// File: rtl/bmt_mask.sv
module bmt_mask #(
  parameter int unsigned MASK_W = bmt_pkg::BMT_MASK_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commutate,
  input  logic              dn_tick,
  input  logic [MASK_W-1:0] load_val,
  output logic [MASK_W-1:0] mask_cnt,
  output logic              mask_active
);
  always_ff @(posedge clk) begin
    if (!rst_n)                        mask_cnt <= '0;
    else if (commutate)                mask_cnt <= load_val;
    else if (dn_tick && mask_cnt != 0) mask_cnt <= mask_cnt - 1'b1;
  end

  assign mask_active = (mask_cnt != '0);
endmodule

// File: rtl/bemf_mask_timer.sv
module bemf_mask_timer #(
  parameter int unsigned PER_W       = bmt_pkg::BMT_PER_W_DEF,
  parameter int unsigned MASK_W      = bmt_pkg::BMT_MASK_W_DEF,
  parameter int unsigned UP_DIV      = bmt_pkg::BMT_UP_DIV_DEF,
  parameter int unsigned SYNC_STAGES = bmt_pkg::BMT_SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commutate,
  input  logic cmp_raw,
  output logic mask_active,
  output logic zc_strobe,
  output logic cmp_masked
);
  logic              up_tick;
  logic              dn_tick;
  logic              cmp_edge;
  logic [PER_W-1:0]  per_cnt;
  logic [MASK_W-1:0] hold_load;
  logic              armed;
  logic [MASK_W-1:0] mask_cnt;

  bmt_prescaler #(.UP_DIV(UP_DIV)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_tick (up_tick),
    .dn_tick (dn_tick)
  );

  bmt_cmp_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_raw  (cmp_raw),
    .freeze   (mask_active),
    .cmp_edge (cmp_edge),
    .cmp_held (cmp_masked)
  );

  // A zero crossing is an edge seen outside the mask.
  assign zc_strobe = cmp_edge & ~mask_active;

  bmt_period #(.PER_W(PER_W), .MASK_W(MASK_W)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_tick   (up_tick),
    .zc        (zc_strobe),
    .per_cnt   (per_cnt),
    .hold_load (hold_load),
    .armed     (armed)
  );

  bmt_mask #(.MASK_W(MASK_W)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .commutate   (commutate),
    .dn_tick     (dn_tick),
    .load_val    (hold_load),
    .mask_cnt    (mask_cnt),
    .mask_active (mask_active)
  );
endmodule

// File: rtl/bmt_checker.sv
module bmt_checker #(
  parameter int unsigned PER_W  = 9,
  parameter int unsigned MASK_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commutate,
  input logic              zc_strobe,
  input logic              mask_active,
  input logic              cmp_masked,
  input logic              up_tick,
  input logic              dn_tick,
  input logic              armed,
  input logic [PER_W-1:0]  per_cnt,
  input logic [MASK_W-1:0] mask_cnt
);
  a_r7_no_zc_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    zc_strobe |-> !mask_active);

  a_r4_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
    zc_strobe |=> (per_cnt == '0) && armed);

  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (per_cnt == '1 && !zc_strobe) |=> per_cnt == '1);

  a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!zc_strobe && !up_tick) |=> $stable(per_cnt));

  a_r6_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!commutate && !dn_tick) |=> $stable(mask_cnt));

  a_r5_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !commutate |=> mask_cnt <= $past(mask_cnt));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mask_active |=> $stable(cmp_masked));
endmodule

bind bemf_mask_timer bmt_checker #(.PER_W(PER_W), .MASK_W(MASK_W)) u_bmt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .commutate   (commutate),
  .zc_strobe   (zc_strobe),
  .mask_active (mask_active),
  .cmp_masked  (cmp_masked),
  .up_tick     (up_tick),
  .dn_tick     (dn_tick),
  .armed       (armed),
  .per_cnt     (per_cnt),
  .mask_cnt    (mask_cnt)
);

// File: tb/test_bemf_mask_timer.sv
module test_bemf_mask_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic commutate = 1'b0;
  logic cmp_raw = 1'b0;
  logic mask_active, zc_strobe, cmp_masked;

  always #5 clk = ~clk;

  bemf_mask_timer i_bemf_mask_timer (
    .clk(clk), .rst_n(rst_n), .commutate(commutate), .cmp_raw(cmp_raw),
    .mask_active(mask_active), .zc_strobe(zc_strobe), .cmp_masked(cmp_masked)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Scoreboard queues
  int zc_q[$];
  int rise_q[$];
  int fall_q[$];

  // Requirement-level model state
  int  z_last = 0;
  bit  seen_zc = 0;
  int  load_m = 0;
  bit  lvl = 0;
  bit  mask_prev = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Prescaled ticks at end of cycles n in [a,b] with n mod 64 == 63 (R3)
  function automatic int up_ticks(input int a, input int b);
    return ((b + 1) / 64) - (a / 64);
  endfunction

  task automatic toggle(input bit expect_zc);
    int k, z, cnt;
    k = cyc;
    cmp_raw = ~cmp_raw;
    lvl = ~lvl;
    if (expect_zc) begin
      z = k + 2;
      zc_q.push_back(z);
      if (seen_zc) begin
        cnt = up_ticks(z_last + 1, z - 1);
        if (cnt > 511) cnt = 511;
        load_m = cnt >> 3;
      end
      z_last = z;
      seen_zc = 1;
    end
  endtask

  task automatic commutate_pulse();
    int c, first, last;
    c = cyc;
    commutate = 1'b1;
    if (load_m > 0) begin
      first = ((c + 1) / 128) * 128 + 127;
      last  = first + (load_m - 1) * 128;
      rise_q.push_back(c + 1);
      fall_q.push_back(last + 1);
    end
    @(negedge clk);
    commutate = 1'b0;
  endtask

  task automatic expect_no_mask(input string req);
    repeat (3) @(negedge clk);
    check(mask_active == 1'b0, req, mask_active, 0);
  endtask

  // Monitor: pops expected events and compares
  always @(negedge clk) begin
    int e;
    if (rst_n && !done) begin
      if (zc_strobe) begin
        if (zc_q.size() == 0) check(1'b0, "R7 unexpected zero crossing", cyc, -1);
        else begin
          e = zc_q.pop_front();
          check(cyc == e, "R2 zero-crossing strobe cycle", cyc, e);
        end
      end
      if (mask_active && !mask_prev) begin
        if (rise_q.size() == 0) check(1'b0, "R5 unexpected mask start", cyc, -1);
        else begin
          e = rise_q.pop_front();
          check(cyc == e, "R5 mask start cycle", cyc, e);
        end
      end
      if (!mask_active && mask_prev) begin
        if (fall_q.size() == 0) check(1'b0, "R6 unexpected mask end", cyc, -1);
        else begin
          e = fall_q.pop_front();
          check(cyc == e, "R6 mask end cycle", cyc, e);
        end
      end
      mask_prev = mask_active;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(mask_active == 1'b0, "R1 mask idle in reset", mask_active, 0);
    check(zc_strobe == 1'b0, "R1 no strobe in reset", zc_strobe, 0);
    check(cmp_masked == 1'b0, "R1 masked output in reset", cmp_masked, 0);
    rst_n = 1'b1;

    // R1: cleared load gives no mask after reset
    wait_to(10); commutate_pulse(); expect_no_mask("R1 load cleared at reset");

    // R4: first crossing only arms measurement
    wait_to(20); toggle(1);
    wait_to(23); check(cmp_masked == lvl, "R8 follows level outside mask", cmp_masked, lvl);
    wait_to(40); commutate_pulse(); expect_no_mask("R4 first crossing stores nothing");

    // R4/R5/R6: load 3 from ~2000-cycle period
    wait_to(2020); toggle(1);
    check(load_m == 3, "R4 model load", load_m, 3);
    wait_to(2100); commutate_pulse();

    // Longer period, then masked toggles (R7, R8)
    wait_to(7100); toggle(1);
    wait_to(7103); check(cmp_masked == lvl, "R8 follows level outside mask", cmp_masked, lvl);
    wait_to(7150); commutate_pulse();
    wait_to(7160); toggle(0);
    wait_to(7170);
    check(cmp_masked == ~lvl, "R8 frozen during mask", cmp_masked, !lvl);
    check(mask_active == 1'b1, "R7 mask open during toggles", mask_active, 1);
    wait_to(7200); toggle(0);
    wait_to(7205); check(cmp_masked == lvl, "R8 frozen during mask", cmp_masked, lvl);

    // R7: placement where accepting masked toggles would give load 4, not 5
    wait_to(9600); toggle(1);
    check(load_m == 5, "R7 model load", load_m, 5);
    wait_to(9700); commutate_pulse();

    // R9: saturated period gives load 63
    wait_to(49600); toggle(1);
    check(load_m == 63, "R9 model saturated load", load_m, 63);
    wait_to(49700); commutate_pulse();

    // Short periods: load 16 (stored only), then 1, then 0
    wait_to(58000); toggle(1);
    wait_to(58600); toggle(1);
    check(load_m == 1, "R6 model truncated load", load_m, 1);
    wait_to(58650); commutate_pulse();
    wait_to(58900); toggle(1);
    wait_to(58950); commutate_pulse(); expect_no_mask("R5 zero load gives no mask");

    repeat (20) @(negedge clk);
    check(zc_q.size() == 0, "R2 all crossings seen", zc_q.size(), 0);
    check(fall_q.size() == 0, "R6 all masks ended", fall_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule